// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block keeps one free-running 64-bit time value shared by a group of harts, plus one 64-bit compare value per hart. A byte-addressed register port lets software read any of these words and rewrite the compare words, in pieces of 1, 2, 4 or 8 bytes at any alignment. Each hart receives a level-sensitive timer-pending line that is high whenever the shared time has reached that hart's compare value.

Time does not advance on every clock. It moves forward by a fixed step, `STEP` (default 50), on each cycle in which the `tick` strobe is high. The bus cannot write the time word. Each pending line is registered and is refreshed in the same clock edge that changes the time or a compare value. As a result, a line falls as soon as software pushes its compare value past the current time.

The register space holds `NUM_HARTS + 1` words of 8 bytes. Time is at byte 0. The compare word for hart h is at byte `8*(h+1)`. Bytes are little-endian.

Top module: `hart_timer`

## Requirements
- R1: While reset is held and after it is released, time and every compare value are zero, `ack`, `err` and `rdata` are zero, and every `mtip` bit is 1 because 0 >= 0.
- R2: Each cycle with `tick` high adds `STEP` to the time value. Time holds its value in every other cycle.
- R3: A read of N bytes, where `size` 0/1/2/3 selects N = 1/2/4/8, returns byte `addr+k` of the register space in `rdata[8k+7:8k]` one cycle after the request. Lanes k >= N read as zero.
- R4: An accepted write of N bytes at any alignment stores `wdata[8k+7:8k]` into byte `addr+k` for k < N. All other bytes keep their values, so each 32-bit half of a compare word can be written on its own.
- R5: A write whose `addr` is below 8 is refused with `err`. No byte changes, so the time value cannot be written.
- R6: An access with `addr + N` greater than `8*(NUM_HARTS+1)` is refused with `err`. No state changes and `rdata` stays zero.
- R7: `mtip[h]` is 1 exactly when time >= compare value h, using an unsigned 64-bit comparison. The line updates in the same edge as any tick or accepted write.
- R8: When a tick and an accepted write fall in the same cycle, both take effect in that edge. The pending lines then reflect both the incremented time and the new compare bytes.
- R9: Every request produces exactly one response, `ack` or `err`, as a one-cycle pulse in the cycle that follows it. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Time advance strobe; adds STEP per high cycle |
| req | input | 1 | Register access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Starting byte offset |
| size | input | 2 | Access length: 0=1, 1=2, 2=4, 3=8 bytes |
| wdata | input | 64 | Write bytes, lane k to byte addr+k |
| rdata | output | 64 | Read bytes, lane k from byte addr+k; zero when unused |
| ack | output | 1 | Access accepted (one-cycle pulse) |
| err | output | 1 | Access refused (one-cycle pulse) |
| mtip | output | NUM_HARTS | Per-hart timer-pending level |

## Verification
A wrong byte in the register space becomes visible at `rdata` on the first read that covers it. If it is a compare byte, it also shows at `mtip` in the cycle after it is stored, whenever it tips the comparison. A wrong time value shows up as a pending line that changes one tick too early or too late, and as a mismatch on the next read of word 0. A decode fault shows in the cycle after the request as the wrong choice between `ack` and `err`, or as a refused access that still changed bytes, which the next read exposes.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;
  localparam int WORD_BYTES = 8;
  localparam int DATA_W     = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction
endpackage

// File: rtl/ht_decode.sv
module ht_decode
  import hart_timer_pkg::*;
#(
  parameter int FILE_BYTES = 24,
  parameter int ADDR_W     = 7
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              acc_err,
  output logic              wr_ok,
  output logic              rd_ok
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(FILE_BYTES);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'(WORD_BYTES);

  logic [ADDR_W:0] end_addr;
  logic            over_end;
  logic            hits_time;

  always_comb begin
    end_addr  = {1'b0, addr} + (ADDR_W+1)'(size_bytes(size));
    over_end  = end_addr > LIMIT;
    hits_time = we && (addr < LOW);
    acc_err   = req && (over_end || hits_time);
    wr_ok     = req && we && !acc_err;
    rd_ok     = req && !we && !acc_err;
  end
endmodule

// File: rtl/ht_regfile.sv
module ht_regfile
  import hart_timer_pkg::*;
#(
  parameter int          NUM_HARTS = 2,
  parameter logic [63:0] STEP      = 64'd50,
  parameter int          ADDR_W    = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                size,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         time_q,
  output logic [NUM_HARTS*64-1:0]   cmp_q,
  output logic [DATA_W-1:0]         time_n,
  output logic [NUM_HARTS*64-1:0]   cmp_n,
  output logic [DATA_W-1:0]         rd_bytes
);
  localparam int CMP_BYTES  = NUM_HARTS * WORD_BYTES;
  localparam int FILE_BYTES = CMP_BYTES + WORD_BYTES;

  logic [FILE_BYTES*8-1:0] file_v;
  int unsigned             base;
  int unsigned             nbytes;

  assign file_v = {cmp_q, time_q};
  assign base   = {{(32-ADDR_W){1'b0}}, addr};
  assign nbytes = {28'd0, size_bytes(size)};

  // next state: time advances by STEP, compare bytes take write lanes
  always_comb begin
    time_n = tick ? time_q + STEP : time_q;
    cmp_n  = cmp_q;
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (wr_en && k < nbytes && base + k >= WORD_BYTES &&
          base + k < FILE_BYTES) begin
        cmp_n[(base + k - WORD_BYTES)*8 +: 8] = wdata[k*8 +: 8];
      end
    end
  end

  // read gather, little-endian lanes
  always_comb begin
    rd_bytes = '0;
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (k < nbytes && base + k < FILE_BYTES) begin
        rd_bytes[k*8 +: 8] = file_v[(base + k)*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (tick)  time_q <= time_n;
      if (wr_en) cmp_q  <= cmp_n;
    end
  end
endmodule

// File: rtl/ht_compare.sv
module ht_compare #(
  parameter int NUM_HARTS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [63:0]             time_n,
  input  logic [NUM_HARTS*64-1:0] cmp_n,
  output logic [NUM_HARTS-1:0]    pend_q
);
  logic [NUM_HARTS-1:0] pend_d;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign pend_d[h] = time_n >= cmp_n[h*64 +: 64];
  end

  // recomputed every edge from the next state, so ticks and writes both refresh it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '1;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int          NUM_HARTS = 2,
  parameter logic [63:0] STEP      = 64'd50,
  parameter int          ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic [63:0]          wdata,
  output logic [63:0]          rdata,
  output logic                 ack,
  output logic                 err,
  output logic [NUM_HARTS-1:0] mtip
);
  localparam int FILE_BYTES = WORD_BYTES * (NUM_HARTS + 1);

  logic [1:0]                rst_pipe;
  logic                      rst_sync_n;
  logic                      acc_err, wr_ok, rd_ok;
  logic [63:0]               time_q, time_n, rd_bytes;
  logic [NUM_HARTS*64-1:0]   cmp_q, cmp_n;
  logic                      ack_d, err_d;
  logic [63:0]               rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ht_decode #(.FILE_BYTES(FILE_BYTES), .ADDR_W(ADDR_W)) u_dec (
    .req(req), .we(we), .addr(addr), .size(size),
    .acc_err(acc_err), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  ht_regfile #(.NUM_HARTS(NUM_HARTS), .STEP(STEP), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .wr_en(wr_ok),
    .addr(addr), .size(size), .wdata(wdata),
    .time_q(time_q), .cmp_q(cmp_q), .time_n(time_n), .cmp_n(cmp_n),
    .rd_bytes(rd_bytes)
  );

  ht_compare #(.NUM_HARTS(NUM_HARTS)) u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .time_n(time_n), .cmp_n(cmp_n),
    .pend_q(mtip)
  );

  always_comb begin
    ack_d   = req && !acc_err;
    err_d   = acc_err;
    rdata_d = rd_ok ? rd_bytes : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= ack_d;
      err   <= err_d;
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk #(
  parameter int          NUM_HARTS = 2,
  parameter logic [63:0] STEP      = 64'd50,
  parameter int          ADDR_W    = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    req,
  input logic                    we,
  input logic [ADDR_W-1:0]       addr,
  input logic [1:0]              size,
  input logic                    ack,
  input logic                    err,
  input logic [NUM_HARTS-1:0]    mtip,
  input logic [63:0]             time_q,
  input logic [NUM_HARTS*64-1:0] cmp_q
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(8 * (NUM_HARTS + 1));

  logic [ADDR_W:0] span_end;
  assign span_end = {1'b0, addr} + ((ADDR_W+1)'(1) << size);

  p_resp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && err));
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (ack || err));
  p_resp_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || err) |-> $past(req));
  p_time_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr < ADDR_W'(8)) |=> err);
  p_past_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && span_end > LIMIT) |=> (err && !ack));
  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_q == $past(time_q) + STEP));
  p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_pend
    p_pend_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mtip[h] == (time_q >= cmp_q[h*64 +: 64]));
  end
endmodule

bind hart_timer hart_timer_chk #(
  .NUM_HARTS(NUM_HARTS), .STEP(STEP), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .req(req), .we(we),
  .addr(addr), .size(size), .ack(ack), .err(err), .mtip(mtip),
  .time_q(time_q), .cmp_q(cmp_q)
);

// File: tb/sim_hart_timer.sv
module sim_hart_timer;
  localparam int          N    = 2;
  localparam logic [63:0] STEP = 64'd50;
  localparam int          AW   = 7;
  localparam int          FB   = 8 * (N + 1);

  logic          clk = 1'b0;
  logic          rst_n, tick, req, we;
  logic [AW-1:0] addr;
  logic [1:0]    size;
  logic [63:0]   wdata, rdata;
  logic          ack, err;
  logic [N-1:0]  mtip;

  always #10 clk = ~clk;

  hart_timer #(.NUM_HARTS(N), .STEP(STEP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .we(we),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata),
    .ack(ack), .err(err), .mtip(mtip)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] mb [0:FB-1];

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] word(input int w);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = mb[w*8 + k];
    return v;
  endfunction

  task automatic set_word(input int w, input logic [63:0] v);
    for (int k = 0; k < 8; k++) mb[w*8 + k] = v[k*8 +: 8];
  endtask

  task automatic check_pend(input string tag);
    for (int h = 0; h < N; h++)
      check(tag, {63'd0, mtip[h]}, {63'd0, word(0) >= word(1 + h)});
  endtask

  task automatic access(input bit w, input int a, input int sz,
                        input logic [63:0] wd, input bit tk,
                        input string ptag);
    int          len;
    bit          e_over, e_low, e_err;
    logic [63:0] exp_rd;
    string       etag;
    len    = 1 << sz;
    e_over = (a + len) > FB;
    e_low  = w && a < 8;
    e_err  = e_over || e_low;
    exp_rd = '0;
    if (!w && !e_err)
      for (int k = 0; k < len; k++) exp_rd[k*8 +: 8] = mb[a + k];
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); size = 2'(sz); wdata = wd; tick = tk;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
    if (tk) set_word(0, word(0) + STEP);
    if (w && !e_err)
      for (int k = 0; k < len; k++) mb[a + k] = wd[k*8 +: 8];
    etag = e_over ? "R6" : (e_low ? "R5" : "R9");
    check(etag, {63'd0, err}, {63'd0, e_err});
    check("R9", {63'd0, ack}, {63'd0, !e_err});
    check(w ? "R4" : (e_over ? "R6" : "R3"), rdata, exp_rd);
    check_pend(ptag);
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    set_word(0, word(0) + STEP);
    check_pend("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; req = 1'b0; we = 1'b0;
    addr = '0; size = '0; wdata = '0;
    for (int i = 0; i < FB; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("R1", {62'd0, ack, err}, 64'd0);
    check("R1", {{(64-N){1'b0}}, mtip}, {{(64-N){1'b0}}, {N{1'b1}}});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", rdata, 64'd0);
    check("R1", {62'd0, ack, err}, 64'd0);
    check("R1", {{(64-N){1'b0}}, mtip}, {{(64-N){1'b0}}, {N{1'b1}}});
    access(1'b0, 0, 3, '0, 1'b0, "R1");
    access(1'b0, 8, 3, '0, 1'b0, "R1");

    // R2: ticks add STEP; idle cycles hold time
    for (int i = 0; i < 3; i++) tick_once();
    repeat (5) @(negedge clk);
    access(1'b0, 0, 3, '0, 1'b0, "R2");
    check("R2", word(0), 3 * STEP);

    // R7: unsigned compare, values above time clear pending
    access(1'b1, 8, 3, 64'd200, 1'b0, "R7");
    access(1'b1, 16, 3, 64'h8000_0000_0000_0000, 1'b0, "R7");
    check("R7", {{(64-N){1'b0}}, mtip}, 64'd0);

    // R3/R6: read sweep over every offset and size
    for (int a = 0; a < 32; a++)
      for (int sz = 0; sz < 4; sz++)
        access(1'b0, a, sz, '0, 1'b0, "R7");

    // R4/R5/R6: write sweep, then read everything back
    for (int a = 0; a < 32; a++)
      for (int sz = 0; sz < 4; sz++)
        access(1'b1, a, sz,
               64'h0123_4567_89AB_CDEF ^ {8{8'(a * 7 + sz * 29)}},
               1'b0, "R7");
    for (int a = 0; a < FB; a += 4)
      access(1'b0, a, 2, '0, 1'b0, "R4");

    // R5: full-width write at offset 0 leaves time untouched
    access(1'b1, 0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5");
    access(1'b0, 0, 3, '0, 1'b0, "R5");
    check("R5", word(0), 3 * STEP);

    // R4: 32-bit halves written on their own
    access(1'b1, 8, 3, 64'd0, 1'b0, "R4");
    access(1'b1, 12, 2, 64'h0000_0000_0000_0001, 1'b0, "R4");
    access(1'b1, 8, 2, 64'h0000_0000_DEAD_BEEF, 1'b0, "R4");
    access(1'b0, 8, 3, '0, 1'b0, "R4");
    check("R4", word(1), 64'h0000_0001_DEAD_BEEF);

    // R7: equality boundary reached by a tick
    access(1'b1, 8, 3, word(0) + STEP, 1'b0, "R7");
    check("R7", {63'd0, mtip[0]}, 64'd0);
    tick_once();
    check("R7", {63'd0, mtip[0]}, 64'd1);
    access(1'b1, 8, 3, word(0) + 64'd1, 1'b0, "R7");
    check("R7", {63'd0, mtip[0]}, 64'd0);

    // R8: write and tick in the same cycle
    access(1'b1, 16, 3, word(0) + STEP, 1'b1, "R8");
    check("R8", {63'd0, mtip[1]}, 64'd1);
    access(1'b1, 16, 3, word(0) + STEP + 64'd1, 1'b1, "R8");
    check("R8", {63'd0, mtip[1]}, 64'd0);
    access(1'b0, 0, 3, '0, 1'b0, "R8");

    // R9: no response without a request
    repeat (2) @(negedge clk);
    check("R9", {62'd0, ack, err}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule